// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block turns pairs of 24-bit two's-complement audio samples into a serial stream. The stream uses one data line, a bit clock and a frame clock. The frame clock marks which channel is on the line. Two framings are available. In the left-justified framing, the left word starts right at the frame-clock edge. In the I2S framing, the left word starts one bit period later.

The block has two roles. As clock master, it divides its own clock, which is the system master clock, down to a bit clock of 64 bits per frame and a frame clock with 50% duty. The divide is chosen from three master-clock-to-frame-rate ratios. As clock slave, it follows a bit clock and a frame clock supplied from outside. In both roles the incoming clock levels are sampled on the master clock, so no second clock domain exists.

Samples arrive on parallel buses with a one-cycle valid strobe and are held. At the start of every frame, the left word and the right word are copied together into the words that get sent. A new sample written while a frame is being sent therefore never corrupts that frame. When a slave frame has only 16 bit periods per channel, each word is cut to its upper 16 bits.

Top module: `stereo_serial_tx`

## Requirements
- R1: Words leave MSB first, and `sdo` changes only in the master-clock cycle that follows a falling edge of the active bit clock.
- R2: With `fmt_i2s`=0 (left-justified), the left word is sent while the frame clock is high. Its MSB is in the first bit period after the frame-clock edge, so a receiver captures it on the first rising bit-clock edge of the half.
- R3: With `fmt_i2s`=1 (I2S), the left word is sent while the frame clock is low and its MSB is in the second bit period of the half. The first bit period of each half carries the previous word's bit at position L−1, counted from its MSB, where L is the length of the previous half. That bit is sent only if it lies within the previous word's width; otherwise the period carries 0.
- R4: With `role_master`=1, `bck_o` has 50% duty with a half period of 2, 3 or 4 master-clock cycles for `ratio_sel` = 0, 1, 2 (the 256, 384 and 512 frame ratios; code 3 acts like 2). `lrck_o` changes only on a falling edge of `bck_o`, and stays for 32 bit periods in each level.
- R5: With `role_master`=0, `bck_o` and `lrck_o` stay low, and the stream follows `bck_in` and `lrck_in`. These must run at no more than a quarter of the master clock, and the frame clock may change only while the bit clock is low.
- R6: When the previous half frame had exactly 16 bit periods, only the upper 16 bits of each word are sent. Halves of 24 or 32 bit periods send all 24 bits.
- R7: Every bit period after a word's last bit within its half is sent as 0.
- R8: `left_in` and `right_in` are taken only in a cycle where `sample_valid` is high; changes to the buses in other cycles have no effect on the stream.
- R9: Both held samples are captured at the start of the left half. Samples written during a frame appear from the next frame on, and the right word sent is always the one captured with its left partner.
- R10: After reset, `sdo` stays 0 until the first frame-clock change has been detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_i2s | input | 1 | 0: left-justified framing, 1: I2S framing |
| role_master | input | 1 | 1: generate the bit and frame clocks, 0: follow external clocks |
| ratio_sel | input | 2 | Master role divide: 0 = 256, 1 = 384, 2/3 = 512 master clocks per frame |
| left_in | input | 24 | Left sample, two's complement |
| right_in | input | 24 | Right sample, two's complement |
| sample_valid | input | 1 | One-cycle strobe that captures both sample buses |
| bck_in | input | 1 | External bit clock (slave role) |
| lrck_in | input | 1 | External frame clock (slave role) |
| sdo | output | 1 | Serial data |
| bck_o | output | 1 | Generated bit clock (master role, else 0) |
| lrck_o | output | 1 | Generated frame clock (master role, else 0) |

## Verification
The bench acts as a receiver. It captures one bit on every rising edge of the bit clock and predicts each bit from the framing, the length of the half, and its own copy of the samples it has written. It goes after four corner cases.

- **I2S carry slot.** Here the first slot of each half carries the last bit of the previous word. A design that cleared this slot would lose the LSB at 48 bits per frame. A design that filled it at 64 bits per frame would put a stray bit on the line.
- **16-slot truncation.** A design that kept 24 bits would push bits of the wrong weight into the next channel.
- **Sample updates.** New samples are written every frame at the start of the right half, and the buses are scrambled without the strobe. A design without the frame-aligned capture would send a right word from the wrong frame. A design that ignored the strobe would send garbage.
- **Master clocks.** The generated clocks are timed for every ratio, which catches wrong divides and frame lengths other than 32 bit periods per half.

// File: rtl/sps_pkg.sv
// Shared definitions for the stereo serial transmitter.
// Assumes: the ratio code is 2 bits; codes above 2 fall back to the largest ratio.
package sps_pkg;

    typedef enum logic [1:0] {
        RATIO_256 = 2'd0,
        RATIO_384 = 2'd1,
        RATIO_512 = 2'd2
    } ratio_e;

    // Half bit-clock period minus one, in master-clock cycles (ratio / 128 - 1).
    function automatic logic [2:0] ratio_half_m1(input logic [1:0] sel);
        case (sel)
            RATIO_256: return 3'd1;
            RATIO_384: return 3'd2;
            default:   return 3'd3;
        endcase
    endfunction

endpackage

// File: rtl/sps_clkgen.sv
// Master-role clock generator: divides the master clock to a 64-slot bit clock
// and a 50% frame clock that changes only on bit-clock falling edges.
// Assumes: ratio_sel and fmt_i2s change only while rst_n is low.
module sps_clkgen #(
    parameter int SLOTS = 32,
    parameter int DIV_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fmt_i2s,
    input  logic [1:0] ratio_sel,
    output logic       bck,
    output logic       lrck
);
    import sps_pkg::*;

    localparam int SLOT_W = $clog2(2 * SLOTS);

    logic [DIV_W-1:0]  div_q;
    logic [DIV_W-1:0]  half_m1;
    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] slot_nxt;
    logic              bck_q;
    logic              lrck_q;

    // Divide terminal count and next slot number.
    always_comb begin
        half_m1  = DIV_W'(ratio_half_m1(ratio_sel));
        slot_nxt = slot_q + 1'b1;
    end

    // Toggle the bit clock every half period; step the slot on each fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            bck_q  <= 1'b0;
            slot_q <= '1;
            lrck_q <= fmt_i2s;
        end else if (div_q >= half_m1) begin
            div_q <= '0;
            bck_q <= ~bck_q;
            if (bck_q) begin
                slot_q <= slot_nxt;
                lrck_q <= ~slot_nxt[SLOT_W-1] ^ fmt_i2s;
            end
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign bck  = bck_q;
    assign lrck = lrck_q;

    // Frame clock moves only together with a falling bit-clock edge.
    assert_lr_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lrck_q) |-> $fell(bck_q));

endmodule

// File: rtl/sps_edge.sv
// Edge detector for a bit-clock level sampled on the master clock.
// Assumes: the level stays stable for at least two master-clock cycles.
module sps_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic lvl_d_q;

    // Remember the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d_q <= 1'b0;
        else        lvl_d_q <= lvl;
    end

    assign rise = lvl & ~lvl_d_q;
    assign fall = ~lvl & lvl_d_q;

endmodule

// File: rtl/sps_shifter.sv
// Serializer: holds strobed samples, copies them at the left-half start,
// counts bit slots per half and drives one bit per bit-clock fall.
// Assumes: rise and fall never coincide; the frame clock changes while bck is low.
module sps_shifter #(
    parameter int W     = 24,
    parameter int SW    = 16,
    parameter int CNT_W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fmt_i2s,
    input  logic         rise,
    input  logic         fall,
    input  logic         lr_lvl,
    input  logic         sample_valid,
    input  logic [W-1:0] left_in,
    input  logic [W-1:0] right_in,
    output logic         sdo
);
    logic [W-1:0]     hold_l_q, hold_r_q, shadow_r_q, cur_w_q, word_n;
    logic             cur_short_q, framed_q, synced_q, lr_rise_q, sdo_q;
    logic [CNT_W-1:0] cnt_q, slot_nxt;
    logic             edge_now, enter_left, half_short, sdo_n;

    // Bit k of a word counted from its MSB, 0 beyond the active width.
    function automatic logic pick_bit(input logic [W-1:0] word, input logic short_w, input int k);
        int lim;
        lim = short_w ? SW : W;
        if (k < 0 || k >= lim) return 1'b0;
        return word[W-1-k];
    endfunction

    // Frame-edge detection, slot stepping and next output bit.
    always_comb begin
        edge_now   = fall && synced_q && (lr_lvl != lr_rise_q);
        enter_left = fmt_i2s ? ~lr_lvl : lr_lvl;
        half_short = (cnt_q == CNT_W'(SW - 1));
        word_n     = enter_left ? hold_l_q : shadow_r_q;
        slot_nxt   = edge_now ? '0 : ((&cnt_q) ? cnt_q : cnt_q + 1'b1);
        if (edge_now)
            sdo_n = fmt_i2s ? pick_bit(cur_w_q, cur_short_q, int'(cnt_q)) : word_n[W-1];
        else if (!framed_q)
            sdo_n = 1'b0;
        else
            sdo_n = pick_bit(cur_w_q, cur_short_q, int'(slot_nxt) - int'(fmt_i2s));
    end

    // Capture strobed samples into the hold registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_l_q <= '0;
            hold_r_q <= '0;
        end else if (sample_valid) begin
            hold_l_q <= left_in;
            hold_r_q <= right_in;
        end
    end

    // Sample the frame clock on bit-clock rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_rise_q <= 1'b0;
            synced_q  <= 1'b0;
        end else if (rise) begin
            lr_rise_q <= lr_lvl;
            synced_q  <= 1'b1;
        end
    end

    // On each bit-clock fall: step the slot, swap words at edges, drive data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            cur_w_q     <= '0;
            shadow_r_q  <= '0;
            cur_short_q <= 1'b0;
            framed_q    <= 1'b0;
            sdo_q       <= 1'b0;
        end else if (fall) begin
            cnt_q <= slot_nxt;
            sdo_q <= sdo_n;
            if (edge_now) begin
                cur_w_q     <= word_n;
                cur_short_q <= half_short;
                framed_q    <= 1'b1;
                if (enter_left) shadow_r_q <= hold_r_q;
            end
        end
    end

    assign sdo = sdo_q;

    // Data moves only right after a bit-clock fall.
    assert_sdo_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_q) |-> $past(fall));

    // Line stays quiet until the first frame edge.
    assert_quiet_unframed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !framed_q |-> !sdo_q);

    // Held samples move only on the strobe.
    assert_hold_on_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |=> ($stable(hold_l_q) && $stable(hold_r_q)));

    // The right shadow changes only at a left-half start.
    assert_shadow_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(edge_now && enter_left) |=> $stable(shadow_r_q));

endmodule

// File: rtl/stereo_serial_tx.sv
// Top: selects generated or external clocks, detects bit-clock edges and
// serializes the left/right samples.
// Assumes: external clocks are synchronous to clk and at most clk/4;
// mode inputs change only during reset.
module stereo_serial_tx #(
    parameter int SAMPLE_W = 24,
    parameter int SHORT_W  = 16,
    parameter int SLOTS    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fmt_i2s,
    input  logic                role_master,
    input  logic [1:0]          ratio_sel,
    input  logic [SAMPLE_W-1:0] left_in,
    input  logic [SAMPLE_W-1:0] right_in,
    input  logic                sample_valid,
    input  logic                bck_in,
    input  logic                lrck_in,
    output logic                sdo,
    output logic                bck_o,
    output logic                lrck_o
);
    localparam int CNT_W = $clog2(2 * SLOTS);

    logic gen_bck, gen_lrck, ext_bck_q, ext_lrck_q;
    logic bck_lvl, lr_lvl, bck_rise, bck_fall;

    sps_clkgen #(.SLOTS(SLOTS), .DIV_W(3)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .fmt_i2s(fmt_i2s), .ratio_sel(ratio_sel),
        .bck(gen_bck), .lrck(gen_lrck)
    );

    // Register the external clocks into the master-clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_bck_q  <= 1'b0;
            ext_lrck_q <= 1'b0;
        end else begin
            ext_bck_q  <= bck_in;
            ext_lrck_q <= lrck_in;
        end
    end

    // Pick the clock source for the serializer.
    always_comb begin
        bck_lvl = role_master ? gen_bck  : ext_bck_q;
        lr_lvl  = role_master ? gen_lrck : ext_lrck_q;
    end

    sps_edge u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(bck_lvl), .rise(bck_rise), .fall(bck_fall)
    );

    sps_shifter #(.W(SAMPLE_W), .SW(SHORT_W), .CNT_W(CNT_W)) u_shifter (
        .clk(clk), .rst_n(rst_n), .fmt_i2s(fmt_i2s), .rise(bck_rise), .fall(bck_fall),
        .lr_lvl(lr_lvl), .sample_valid(sample_valid), .left_in(left_in),
        .right_in(right_in), .sdo(sdo)
    );

    assign bck_o  = role_master & gen_bck;
    assign lrck_o = role_master & gen_lrck;

endmodule

// File: tb/stereo_serial_tx_test.sv
module stereo_serial_tx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fmt_i2s = 1'b0, role_master = 1'b0;
    logic [1:0]  ratio_sel = 2'd0;
    logic [23:0] left_in = '0, right_in = '0;
    logic        sample_valid = 1'b0, bck_in = 1'b0, lrck_in = 1'b0;
    logic        sdo, bck_o, lrck_o;

    stereo_serial_tx uut (
        .clk(clk), .rst_n(rst_n), .fmt_i2s(fmt_i2s), .role_master(role_master),
        .ratio_sel(ratio_sel), .left_in(left_in), .right_in(right_in),
        .sample_valid(sample_valid), .bck_in(bck_in), .lrck_in(lrck_in),
        .sdo(sdo), .bck_o(bck_o), .lrck_o(lrck_o)
    );

    always #4 clk = ~clk;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    // receiver / model state
    int halves, j, L_prev, wid, prev_wid, rise_cyc, half_clk, nsmp;
    logic b_prev, lr_last;
    logic [23:0] held_l, held_r, sh_l, sh_r, cur_word, prev_word;
    logic [31:0] lfsr = 32'h1ACE_B00C;
    // slave stimulus state
    int sc, sslot, slave_L;
    localparam int HALFP = 8;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic exp_bit(input logic [23:0] w, input int width, input int k);
        if (k < 0 || k >= width) return 1'b0;
        return w[23-k];
    endfunction

    task automatic drive_new();
        logic [23:0] a, b;
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        case (nsmp % 6)
            0: begin a = 24'h800000; b = 24'h7FFFFF; end
            1: begin a = 24'h7FFFFF; b = 24'h800000; end
            2: begin a = 24'h000001; b = 24'hFFFFFF; end
            default: begin a = lfsr[23:0]; b = lfsr[31:8] ^ 24'h3C3C3C; end
        endcase
        nsmp++;
        left_in = a; right_in = b; sample_valid = 1'b1;
        held_l = a; held_r = b;
    endtask

    task automatic on_rise(input logic lr, input logic d);
        logic e; int k; string tag; logic left;
        if (role_master) begin
            if (halves >= 2) check(cyc - rise_cyc == 2 * half_clk, "R4 bck period", cyc - rise_cyc, 2 * half_clk);
            rise_cyc = cyc;
        end else begin
            check(bck_o == 1'b0 && lrck_o == 1'b0, "R5 clocks idle in slave", {bck_o, lrck_o}, 0);
        end
        if (lr != lr_last) begin
            L_prev = j + 1;
            halves++;
            if (role_master && halves >= 3) check(L_prev == 32, "R4 half length", L_prev, 32);
            prev_word = cur_word; prev_wid = wid;
            wid = (L_prev == 16) ? 16 : 24;
            left = fmt_i2s ? ~lr : lr;
            if (left) begin
                sh_l = held_l; sh_r = held_r; cur_word = sh_l;
                // scramble buses without strobe: must be ignored (R8)
                left_in = held_l ^ 24'hA5A5A5; right_in = ~held_r;
            end else begin
                cur_word = sh_r;
                if (halves >= 1) drive_new();  // mid-frame update (R9)
            end
            j = 0;
        end else begin
            j++;
        end
        lr_last = lr;
        if (halves == 0) begin
            check(d == 1'b0, "R10 quiet before first frame", d, 0);
        end else if (halves >= 4) begin
            if (fmt_i2s && j == 0) begin
                k = L_prev - 1; e = exp_bit(prev_word, prev_wid, k); tag = "R3 carry slot";
            end else begin
                k = fmt_i2s ? j - 1 : j; e = exp_bit(cur_word, wid, k);
                if (k >= 24) tag = "R7 pad zero";
                else if (k >= wid) tag = "R6 truncation";
                else tag = fmt_i2s ? "R3 R1 R8 R9 data bit" : "R2 R1 R8 R9 data bit";
            end
            check(d == e, tag, d, e);
        end
    endtask

    task automatic tick();
        logic cb, cl;
        @(negedge clk);
        cyc++;
        sample_valid = 1'b0;
        cb = role_master ? bck_o : bck_in;
        cl = role_master ? lrck_o : lrck_in;
        if (rst_n && cb && !b_prev) on_rise(cl, sdo);
        if (rst_n && role_master && !cb && b_prev && halves >= 2)
            check(cyc - rise_cyc == half_clk, "R4 bck duty", cyc - rise_cyc, half_clk);
        b_prev = cb;
        if (rst_n && !role_master) begin
            sc++;
            if (sc == HALFP) begin
                sc = 0;
                if (bck_in) begin
                    bck_in = 1'b0;
                    sslot++;
                    if (sslot == slave_L) begin sslot = 0; lrck_in = ~lrck_in; end
                end else begin
                    bck_in = 1'b1;
                end
            end
        end
    endtask

    task automatic run_cfg(input logic f, input logic m, input logic [1:0] r, input int sl);
        int guard;
        rst_n = 1'b0; fmt_i2s = f; role_master = m; ratio_sel = r; slave_L = sl;
        bck_in = 1'b0; lrck_in = f; sc = 0; sslot = 0;
        half_clk = (r == 2'd0) ? 2 : (r == 2'd1) ? 3 : 4;
        for (int i = 0; i < 4; i++) tick();
        halves = 0; j = 0; L_prev = 0; wid = 24; prev_wid = 24; rise_cyc = cyc;
        b_prev = 1'b0; lr_last = f; held_l = '0; held_r = '0;
        sh_l = '0; sh_r = '0; cur_word = '0; prev_word = '0;
        rst_n = 1'b1;
        tick();
        check(sdo == 1'b0 && bck_o == 1'b0, "R10 reset state", {sdo, bck_o}, 0);
        guard = 0;
        while (halves < 14 && guard < 20000) begin
            tick();
            guard++;
        end
        if (guard >= 20000) check(1'b0, "watchdog expired", halves, 14);
    endtask

    initial begin
        // master role: every ratio, both framings
        for (int r = 0; r < 4; r++) begin
            run_cfg(1'b0, 1'b1, 2'(r), 32);
            run_cfg(1'b1, 1'b1, 2'(r), 32);
        end
        // slave role: 32, 48 and 64 bit periods per frame
        for (int f = 0; f < 2; f++) begin
            run_cfg(1'(f), 1'b0, 2'd0, 16);
            run_cfg(1'(f), 1'b0, 2'd0, 24);
            run_cfg(1'(f), 1'b0, 2'd2, 32);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule